// File: doc/BRIEF.md
# Multiplierless Angular Sample Predictor

This block produces four directional intra-prediction samples per clock from a short run of reference neighbours. Each cycle a controller supplies a window of five consecutive 8-bit neighbours, a mode bit that selects either plain copy or two-tap blending, and one 5-bit blend weight. All four lanes share that single control word. Lane `i` reads neighbours `i` and `i+1` of the window.

In blend mode each lane forms `((32-w)*a + w*b + 16) >> 5`, where `a` is its own neighbour and `b` is the next one. No multiplier is used. Each weight bit gates a shifted copy of its neighbour, and the resulting terms are summed in a binary tree of two-input adders, with exactly one adder level per pipeline stage. Copy mode sends the weight pair (32, 0) down the same tree, so both modes have the same latency. A valid bit travels beside the data.

Deriving angles and weights is outside the block, as are reference smoothing and flat-average prediction.

Top module: `angpred_top`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, `out_valid` is 0 and every output lane is 0.
- R2: With `in_frac` = 0 (copy mode), lane `i` outputs neighbour `i`. Neighbour `n` occupies bits `[8n+7:8n]` of `in_nbr`, and `in_wgt` has no effect on the result.
- R3: With `in_frac` = 1 (blend mode) and weight `w` = `in_wgt`, lane `i` outputs `((32-w)*nbr[i] + w*nbr[i+1] + 16) >> 5`. For `w` = 16 this is `(nbr[i]+nbr[i+1]+1)>>1`, and the result always lies between the two neighbours.
- R4: R3 holds for every weight from 1 to 31, including neighbour values 0 and 255.
- R5: A result appears on the fourth rising edge after the edge that samples its input, which is five register stages. The delay is the same in both modes.
- R6: A cycle with `in_valid` = 0 yields a cycle with `out_valid` = 0 at the matching output slot, whatever the other inputs hold. Gaps neither drop nor reorder valid results.
- R7: Mode and weight may change every cycle, and each result uses only the control word of its own input cycle.
- R8: All four lanes use the same mode and weight in a given cycle, while each lane reads its own neighbour pair.
- R9: In blend mode, when both neighbours of a lane are equal, that lane outputs the neighbour value for any weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input window and control word are valid |
| in_frac | input | 1 | 0 = copy mode, 1 = blend mode |
| in_wgt | input | 5 | Blend weight applied to the upper neighbour of each lane |
| in_nbr | input | 40 | Five 8-bit neighbours, neighbour 0 in the low byte |
| out_valid | output | 1 | Output lanes carry a result |
| out_samp | output | 32 | Four 8-bit predicted samples, lane 0 in the low byte |

## Verification
The checker assumes that after reset the only thing that gives meaning to the data lanes is the delayed valid bit. Its properties therefore relate each output to the window and control word captured five cycles earlier, and only when that captured valid was set. Blend-mode properties assume the weight lies between 1 and 31. The bench keeps every valid weight inside that range and covers all 31 values. It drives arbitrary values, including zero, only in copy mode or on cycles with `in_valid` low, where R2 and R6 say the weight must not matter.

// File: rtl/angpred_pkg.sv
package angpred_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_SAMP_W = 8;
    localparam int DEF_WGT_W  = 5;

    typedef enum logic {
        PM_COPY  = 1'b0,
        PM_BLEND = 1'b1
    } pmode_e;

    // leaves: (WGT_W+1) lower-weight bits, WGT_W upper-weight bits, one rounding term
    function automatic int leaf_terms(int wgt_w);
        return 2 * wgt_w + 2;
    endfunction

    function automatic int tree_levels(int wgt_w);
        return $clog2(leaf_terms(wgt_w));
    endfunction

    // one partial-product stage plus one stage per adder level
    function automatic int pipe_latency(int wgt_w);
        return tree_levels(wgt_w) + 1;
    endfunction

endpackage

// File: rtl/angpred_ppgen.sv
module angpred_ppgen #(
    parameter int SAMP_W = 8,
    parameter int WGT_W  = 5,
    parameter int NLEAF  = 16,
    parameter int ACC_W  = SAMP_W + WGT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] a,
    input  logic [SAMP_W-1:0] b,
    input  logic [WGT_W:0]    k0,
    input  logic [WGT_W-1:0]  k1,
    output logic [ACC_W-1:0]  leaf [NLEAF]
);

    localparam int A_TERMS  = WGT_W + 1;
    localparam int B_FIRST  = A_TERMS;
    localparam int RND_IDX  = A_TERMS + WGT_W;
    localparam logic [ACC_W-1:0] ROUND_C = ACC_W'(1) << (WGT_W - 1);

    logic [ACC_W-1:0] pp_d [NLEAF];

    // each leaf is a gated, shifted copy of a neighbour: no adder in this stage
    for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
        if (j < A_TERMS) begin : g_a
            assign pp_d[j] = k0[j] ? (ACC_W'(a) << j) : '0;
        end else if (j < RND_IDX) begin : g_b
            assign pp_d[j] = k1[j-B_FIRST] ? (ACC_W'(b) << (j - B_FIRST)) : '0;
        end else if (j == RND_IDX) begin : g_rnd
            assign pp_d[j] = ROUND_C;
        end else begin : g_pad
            assign pp_d[j] = '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < NLEAF; j++) begin
            if (rst) leaf[j] <= '0;
            else     leaf[j] <= pp_d[j];
        end
    end

endmodule

// File: rtl/angpred_tree.sv
module angpred_tree #(
    parameter int NLEAF  = 16,
    parameter int LEVELS = 4,
    parameter int ACC_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] leaf [NLEAF],
    output logic [ACC_W-1:0] root
);

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int CNT = NLEAF >> (l + 1);

        logic [ACC_W-1:0] src   [2*CNT];
        logic [ACC_W-1:0] sum_q [CNT];

        if (l == 0) begin : g_src_leaf
            for (genvar s = 0; s < 2*CNT; s++) begin : g_s
                assign src[s] = leaf[s];
            end
        end else begin : g_src_prev
            for (genvar s = 0; s < 2*CNT; s++) begin : g_s
                assign src[s] = g_lvl[l-1].sum_q[s];
            end
        end

        // a single two-input adder between registers at every level
        always_ff @(posedge clk) begin
            for (int n = 0; n < CNT; n++) begin
                if (rst) sum_q[n] <= '0;
                else     sum_q[n] <= src[2*n] + src[2*n+1];
            end
        end
    end

    assign root = g_lvl[LEVELS-1].sum_q[0];

endmodule

// File: rtl/angpred_lane.sv
module angpred_lane
    import angpred_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int WGT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] a,
    input  logic [SAMP_W-1:0] b,
    input  logic [WGT_W:0]    k0,
    input  logic [WGT_W-1:0]  k1,
    output logic [SAMP_W-1:0] samp
);

    localparam int LEVELS = tree_levels(WGT_W);
    localparam int NLEAF  = 1 << LEVELS;
    localparam int ACC_W  = SAMP_W + WGT_W;

    logic [ACC_W-1:0] leaf [NLEAF];
    logic [ACC_W-1:0] root;
    logic             frac_unused;

    angpred_ppgen #(
        .SAMP_W (SAMP_W),
        .WGT_W  (WGT_W),
        .NLEAF  (NLEAF),
        .ACC_W  (ACC_W)
    ) u_ppgen (
        .clk  (clk),
        .rst  (rst),
        .a    (a),
        .b    (b),
        .k0   (k0),
        .k1   (k1),
        .leaf (leaf)
    );

    angpred_tree #(
        .NLEAF  (NLEAF),
        .LEVELS (LEVELS),
        .ACC_W  (ACC_W)
    ) u_tree (
        .clk  (clk),
        .rst  (rst),
        .leaf (leaf),
        .root (root)
    );

    // the divide by the weight sum is pure wiring
    assign samp        = root[ACC_W-1 -: SAMP_W];
    assign frac_unused = ^root[WGT_W-1:0];

endmodule

// File: rtl/angpred_top.sv
module angpred_top
    import angpred_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int WGT_W  = DEF_WGT_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_frac,
    input  logic [WGT_W-1:0]          in_wgt,
    input  logic [(LANES+1)*SAMP_W-1:0] in_nbr,
    output logic                      out_valid,
    output logic [LANES*SAMP_W-1:0]   out_samp
);

    localparam int LAT = pipe_latency(WGT_W);
    localparam logic [WGT_W:0] WSUM = (WGT_W + 1)'(1) << WGT_W;

    pmode_e           mode;
    logic [WGT_W-1:0] k1_eff;
    logic [WGT_W:0]   k0_eff;
    logic [LAT-1:0]   vld_q;

    // shared control word; copy mode becomes the weight pair (WSUM, 0)
    assign mode   = pmode_e'(in_frac);
    assign k1_eff = (mode == PM_BLEND) ? in_wgt : '0;
    assign k0_eff = WSUM - {1'b0, k1_eff};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        angpred_lane #(
            .SAMP_W (SAMP_W),
            .WGT_W  (WGT_W)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .a    (in_nbr[i*SAMP_W +: SAMP_W]),
            .b    (in_nbr[(i+1)*SAMP_W +: SAMP_W]),
            .k0   (k0_eff),
            .k1   (k1_eff),
            .samp (out_samp[i*SAMP_W +: SAMP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[LAT-2:0], in_valid};
    end

    assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/angpred_chk.sv
module angpred_chk
    import angpred_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int WGT_W  = DEF_WGT_W
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        in_frac,
    input logic [WGT_W-1:0]            in_wgt,
    input logic [(LANES+1)*SAMP_W-1:0] in_nbr,
    input logic                        out_valid,
    input logic [LANES*SAMP_W-1:0]     out_samp
);

    localparam int LAT = pipe_latency(WGT_W);
    localparam int NBW = (LANES + 1) * SAMP_W;
    localparam logic [WGT_W-1:0] HALF_W = WGT_W'(1) << (WGT_W - 1);

    logic             vd [LAT];
    logic             fd [LAT];
    logic [WGT_W-1:0] wd [LAT];
    logic [NBW-1:0]   nd [LAT];
    logic             rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        for (int s = 0; s < LAT; s++) begin
            if (rst) begin
                vd[s] <= 1'b0;
                fd[s] <= 1'b0;
                wd[s] <= '0;
                nd[s] <= '0;
            end else if (s == 0) begin
                vd[s] <= in_valid;
                fd[s] <= in_frac;
                wd[s] <= in_wgt;
                nd[s] <= in_nbr;
            end else begin
                vd[s] <= vd[s-1];
                fd[s] <= fd[s-1];
                wd[s] <= wd[s-1];
                nd[s] <= nd[s-1];
            end
        end
    end

    // R1
    always @(posedge clk) begin
        if (rst_q) begin
            reset_quiet_chk: assert (out_valid == 1'b0 && out_samp == '0)
                else $error("outputs not cleared after reset");
        end
    end

    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vd[LAT-1]);

    for (genvar l = 0; l < LANES; l++) begin : g_lchk
        logic [SAMP_W-1:0] pa, pb, po;
        assign pa = nd[LAT-1][l*SAMP_W +: SAMP_W];
        assign pb = nd[LAT-1][(l+1)*SAMP_W +: SAMP_W];
        assign po = out_samp[l*SAMP_W +: SAMP_W];

        // R2
        copy_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (vd[LAT-1] && !fd[LAT-1]) |-> po == pa);

        // R3
        blend_bound_chk: assert property (@(posedge clk) disable iff (rst)
            (vd[LAT-1] && fd[LAT-1]) |->
                ((po >= pa && po <= pb) || (po >= pb && po <= pa)));

        // R3
        blend_mid_chk: assert property (@(posedge clk) disable iff (rst)
            (vd[LAT-1] && fd[LAT-1] && wd[LAT-1] == HALF_W) |->
                ({1'b0, po} == (({1'b0, pa} + {1'b0, pb} + 1'b1) >> 1)));

        // R9
        flat_pair_chk: assert property (@(posedge clk) disable iff (rst)
            (vd[LAT-1] && fd[LAT-1] && pa == pb) |-> po == pa);
    end

endmodule

bind angpred_top angpred_chk #(
    .LANES  (LANES),
    .SAMP_W (SAMP_W),
    .WGT_W  (WGT_W)
) u_chk (.*);

// File: tb/angpred_top_tb.sv
module angpred_top_tb;
    import angpred_pkg::*;

    localparam int LANES = DEF_LANES;
    localparam int SW    = DEF_SAMP_W;
    localparam int WW    = DEF_WGT_W;
    localparam int LAT   = pipe_latency(WW);
    localparam int NB    = (LANES + 1) * SW;
    localparam int OW    = LANES * SW;
    localparam int DEPTH = 8192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_frac = 1'b0;
    logic [WW-1:0] in_wgt = '0;
    logic [NB-1:0] in_nbr = '0;
    logic          out_valid;
    logic [OW-1:0] out_samp;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit mon_en = 1'b0;

    bit            exp_v [DEPTH];
    logic [OW-1:0] exp_d [DEPTH];
    string         exp_t [DEPTH];

    always #10ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    angpred_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_frac   (in_frac),
        .in_wgt    (in_wgt),
        .in_nbr    (in_nbr),
        .out_valid (out_valid),
        .out_samp  (out_samp)
    );

    function automatic logic [SW-1:0] ref_lane(bit frac, int w, int a, int b);
        int r;
        if (!frac) return SW'(a);
        r = ((1 << WW) - w) * a + w * b + (1 << (WW - 1));
        return SW'(r >> WW);
    endfunction

    function automatic logic [NB-1:0] rnd_nbr();
        return NB'({$urandom(), $urandom()});
    endfunction

    // drive one cycle; a valid cycle books its expected result LAT negedges later
    task automatic push(bit v, bit frac, logic [WW-1:0] w, logic [NB-1:0] nbr, string tag);
        @(negedge clk);
        in_valid = v;
        in_frac  = frac;
        in_wgt   = w;
        in_nbr   = nbr;
        if (v && (cyc + LAT) < DEPTH) begin
            logic [OW-1:0] e;
            for (int l = 0; l < LANES; l++)
                e[l*SW +: SW] = ref_lane(frac, int'(w), int'(nbr[l*SW +: SW]),
                                         int'(nbr[(l+1)*SW +: SW]));
            exp_v[cyc+LAT] = 1'b1;
            exp_d[cyc+LAT] = e;
            exp_t[cyc+LAT] = tag;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++)
            push(1'b0, 1'($urandom()), WW'($urandom()), rnd_nbr(), "");
    endtask

    // scoreboard: every cycle checks valid; valid cycles check all lanes
    always @(negedge clk) begin
        if (mon_en && cyc < DEPTH) begin
            n_chk++;
            if (out_valid !== exp_v[cyc]) begin
                n_err++;
                $display("FAIL %s cycle %0d out_valid got %b exp %b",
                         exp_v[cyc] ? exp_t[cyc] : "R6", cyc, out_valid, exp_v[cyc]);
            end
            if (exp_v[cyc]) begin
                n_chk++;
                if (out_samp !== exp_d[cyc]) begin
                    n_err++;
                    $display("FAIL %s cycle %0d out_samp got %h exp %h",
                             exp_t[cyc], cyc, out_samp, exp_d[cyc]);
                end
            end
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        @(negedge clk);
        n_chk++;
        // R1: cleared outputs while reset is held
        if (out_valid !== 1'b0 || out_samp !== '0) begin
            n_err++;
            $display("FAIL R1 reset state got v=%b d=%h exp v=0 d=0", out_valid, out_samp);
        end
        rst = 1'b0;
        mon_en = 1'b1;
        idle(2);
    endtask

    task automatic t_latency();
        // R5: lone results in both modes, valid expected only in the booked slot
        push(1'b1, 1'b0, 5'd9, 40'h11_22_33_44_55, "R5");
        idle(LAT + 2);
        push(1'b1, 1'b1, 5'd9, 40'h11_22_33_44_55, "R5");
        idle(LAT + 2);
    endtask

    task automatic t_integer();
        // R2: copy mode, weight carries junk
        push(1'b1, 1'b0, 5'd31, 40'h05_04_03_02_01, "R2");
        push(1'b1, 1'b0, 5'd0,  40'hFF_00_FF_00_FF, "R2");
        for (int i = 0; i < 6; i++)
            push(1'b1, 1'b0, WW'($urandom()), rnd_nbr(), "R2");
        idle(LAT + 1);
    endtask

    task automatic t_fractional();
        // R3: hand-picked blends
        push(1'b1, 1'b1, 5'd16, 40'h00_FF_00_FF_00, "R3");
        push(1'b1, 1'b1, 5'd1,  40'h00_FF_00_FF_00, "R3");
        push(1'b1, 1'b1, 5'd31, 40'h80_40_20_10_08, "R3");
        push(1'b1, 1'b1, 5'd16, 40'h01_02_01_02_01, "R3");
        idle(LAT + 1);
    endtask

    task automatic t_weights();
        // R4: every legal weight with extreme and random pairs
        for (int w = 1; w < (1 << WW); w++) begin
            push(1'b1, 1'b1, WW'(w), 40'h00_FF_00_FF_00, "R4");
            push(1'b1, 1'b1, WW'(w), 40'hFF_00_FF_00_FF, "R4");
            for (int r = 0; r < 4; r++)
                push(1'b1, 1'b1, WW'(w), rnd_nbr(), "R4");
        end
        idle(LAT + 1);
    endtask

    task automatic t_mixed();
        // R7: mode and weight change every cycle
        for (int i = 0; i < 40; i++)
            push(1'b1, 1'(i & 1), WW'(1 + (i * 7) % 31), rnd_nbr(), "R7");
        idle(LAT + 1);
    endtask

    task automatic t_bubbles();
        // R6: gaps with live-looking junk must not emit or shift results
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 1) idle(1 + (i % 2));
            push(1'b1, 1'b1, WW'(1 + $urandom_range(0, 30)), rnd_nbr(), "R6");
        end
        idle(LAT + 1);
    endtask

    task automatic t_shared();
        // R8: distinct pairs per lane under one control word
        push(1'b1, 1'b1, 5'd7,  40'hD2_A0_6E_3C_0A, "R8");
        push(1'b1, 1'b1, 5'd25, 40'h0A_3C_6E_A0_D2, "R8");
        push(1'b1, 1'b0, 5'd25, 40'h0A_3C_6E_A0_D2, "R8");
        idle(LAT + 1);
    endtask

    task automatic t_equal();
        // R9: flat neighbours stay flat for any weight
        for (int w = 1; w < (1 << WW); w += 5)
            push(1'b1, 1'b1, WW'(w), {5{8'($urandom())}}, "R9");
        push(1'b1, 1'b1, 5'd31, 40'hFF_FF_FF_FF_FF, "R9");
        push(1'b1, 1'b1, 5'd1,  40'h00_00_00_00_00, "R9");
        idle(LAT + 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        t_reset();
        t_latency();
        t_integer();
        t_fractional();
        t_weights();
        t_mixed();
        t_bubbles();
        t_shared();
        t_equal();
        idle(4);
        finish_run();
    end

    initial begin
        #3ms;
        n_err++;
        n_chk++;
        $display("FAIL watchdog run did not complete got timeout exp finish");
        finish_run();
    end

endmodule